// File: doc/BRIEF.md
# Storage PHY Power Sequencer

This block is a hardware controller that powers the calibration pad and the delay-locked loop of a storage-interface PHY up and down in a fixed order, in place of software doing the same steps. A one-cycle request chooses power-on or power-off and carries the measured card clock rate in MHz. The controller then steps the PHY control lines one at a time, waits on the calibration-done and DLL-ready status lines with separate timeouts, and reports the result through busy, done and error flags.

A power-off request drives the power-down-bar line low, then the DLL enable low, and finishes. A power-on request first turns on the delayed transmit clock and the output tap delay, then runs the same shut-down steps, waits for the pad to settle, and releases power-down-bar. Once calibration is done, it loads a DLL frequency band code derived from the clock rate and enables the DLL. It then waits for lock unless the rate is zero, since the DLL cannot lock without a clock. All waits count an external one-microsecond tick. The status lines are brought into the clock domain through a two-flop synchroniser.

The request is a plain control strobe, not a stream: there is no ready signal. While `busy` is high, requests are dropped. Apart from the request fields, no data moves through the block.

Top module: `phy_pwr_seq`

## Requirements
- R1: After reset, `pwr_dn_b`, `dll_en`, `freq_sel`, `txclk_dly_sel`, `otap_en`, `otap_sel`, `busy`, `done`, `err_cal`, `err_lock` and `warn_fast` are all 0.
- R2: A request with `req_on`=0 drives `pwr_dn_b` low one cycle after acceptance and `dll_en` low in the next cycle. In that same cycle `done` rises and `busy` falls.
- R3: A request with `req_on`=1 sets `txclk_dly_sel`, then `otap_en`, then `otap_sel`=TAP_VAL (default 2), one per cycle. These steps come before the `pwr_dn_b`-low and `dll_en`-low steps of R2.
- R4: On power-on, `pwr_dn_b` rises only once SETTLE_US+1 ticks have been seen after `dll_en` was driven low. It rises in the cycle of that last tick, which guarantees a settle time of at least SETTLE_US microseconds.
- R5: After `pwr_dn_b` rises, if the synchronised calibration-done is not seen before CAL_TMO_US ticks, the sequence stops with `err_cal`=1, `busy`=0 and `dll_en` still 0.
- R6: After calibration is done, `freq_sel` is loaded, and `dll_en` rises in the following cycle. The code is 0 for 170..200 MHz, 1 for 140..169, 2 for 110..139, 3 for 80..109, 4 for 50..79, and 0 for any other rate, so a shared boundary value takes the higher band.
- R7: With a rate of 0 MHz, `done` rises in the same cycle as `dll_en`, and no lock wait takes place.
- R8: With a non-zero rate, a synchronised DLL-ready ends the sequence with `done`=1. If DLL-ready has not been seen after LOCK_TMO_US ticks, the sequence ends with `err_lock`=1 instead.
- R9: `warn_fast` is set when a power-on request is accepted with a rate above WARN_MHZ (default 175). The sequence runs on regardless. The flag is cleared when the next request is accepted.
- R10: The status inputs reach the sequencer through two flops. A DLL-ready that rises before a clock edge ends the lock wait, and `done` is visible three edges later.
- R11: Requests are ignored while `busy`=1. `done`, `err_cal` and `err_lock` all clear when the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| req_valid | input | 1 | Request strobe, accepted when not busy |
| req_on | input | 1 | 1 = power on, 0 = power off |
| rate_mhz | input | RATE_W | Card clock rate in MHz |
| cal_done_in | input | 1 | Calibration done status (asynchronous) |
| dll_rdy_in | input | 1 | DLL ready status (asynchronous) |
| pwr_dn_b | output | 1 | Pad power-down-bar |
| dll_en | output | 1 | DLL enable |
| freq_sel | output | 3 | DLL frequency band code |
| txclk_dly_sel | output | 1 | Delayed transmit clock select |
| otap_en | output | 1 | Output tap delay enable |
| otap_sel | output | 4 | Output tap delay select |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last sequence completed |
| err_cal | output | 1 | Calibration timeout |
| err_lock | output | 1 | DLL lock timeout |
| warn_fast | output | 1 | Clock rate above WARN_MHZ |

## Verification
The bench builds the block with SETTLE_US=5, CAL_TMO_US=20 and LOCK_TMO_US=40, and drives the microsecond tick once every four clocks. With these values a calibration timeout and a lock timeout each happen within a few hundred cycles. Many runs therefore fit in one bench: rates on every band boundary and just outside the bands, the zero-rate shortcut, and a request dropped while busy. The default 50 ms lock window is only a counter limit, and these runs exercise it at a reduced value.

// File: rtl/phy_pwr_seq_pkg.sv
package phy_pwr_seq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_TXSEL, ST_OTEN, ST_OTSEL, ST_PDB_LO, ST_DLL_LO,
    ST_SETTLE, ST_CAL_W, ST_FREQ, ST_DLL_ON, ST_LOCK_W
  } seq_st_e;

  localparam int BAND_W = 3;
  localparam int TAP_W  = 4;
endpackage

// File: rtl/seq_sync.sv
module seq_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/seq_band.sv
module seq_band import phy_pwr_seq_pkg::*; #(
  parameter int RATE_W = 9
) (
  input  logic [RATE_W-1:0] rate,
  output logic [BAND_W-1:0] code
);
  localparam logic [RATE_W-1:0] TOP = RATE_W'(200);
  localparam logic [RATE_W-1:0] L0  = RATE_W'(170);
  localparam logic [RATE_W-1:0] L1  = RATE_W'(140);
  localparam logic [RATE_W-1:0] L2  = RATE_W'(110);
  localparam logic [RATE_W-1:0] L3  = RATE_W'(80);
  localparam logic [RATE_W-1:0] L4  = RATE_W'(50);

  always_comb begin
    if (rate > TOP)      code = 3'd0;
    else if (rate >= L0) code = 3'd0;
    else if (rate >= L1) code = 3'd1;
    else if (rate >= L2) code = 3'd2;
    else if (rate >= L3) code = 3'd3;
    else if (rate >= L4) code = 3'd4;
    else                 code = 3'd0;
  end
endmodule

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (clr)                 cnt <= '0;
    else if (tick && (cnt != '1)) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/phy_pwr_seq.sv
module phy_pwr_seq import phy_pwr_seq_pkg::*; #(
  parameter int RATE_W      = 9,
  parameter int SETTLE_US   = 5,
  parameter int CAL_TMO_US  = 50,
  parameter int LOCK_TMO_US = 50000,
  parameter int WARN_MHZ    = 175,
  parameter int TAP_VAL     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              us_tick,
  input  logic              req_valid,
  input  logic              req_on,
  input  logic [RATE_W-1:0] rate_mhz,
  input  logic              cal_done_in,
  input  logic              dll_rdy_in,
  output logic              pwr_dn_b,
  output logic              dll_en,
  output logic [2:0]        freq_sel,
  output logic              txclk_dly_sel,
  output logic              otap_en,
  output logic [3:0]        otap_sel,
  output logic              busy,
  output logic              done,
  output logic              err_cal,
  output logic              err_lock,
  output logic              warn_fast
);
  localparam int M1     = (SETTLE_US + 1 > CAL_TMO_US) ? SETTLE_US + 1 : CAL_TMO_US;
  localparam int MAXCNT = (M1 > LOCK_TMO_US) ? M1 : LOCK_TMO_US;
  localparam int CNT_W  = $clog2(MAXCNT + 2);
  localparam logic [CNT_W-1:0] SETTLE_END = CNT_W'(SETTLE_US);
  localparam logic [CNT_W-1:0] CAL_END    = CNT_W'(CAL_TMO_US - 1);
  localparam logic [CNT_W-1:0] LOCK_END   = CNT_W'(LOCK_TMO_US - 1);
  localparam logic [RATE_W-1:0] WARN_LIM  = RATE_W'(WARN_MHZ);
  localparam logic [TAP_W-1:0]  TAP_CODE  = TAP_W'(TAP_VAL);

  seq_st_e           st_q, st_d;
  logic              on_q;
  logic [RATE_W-1:0] rate_q;
  logic [1:0]        stat_s;
  logic              cal_s, dll_s;
  logic [CNT_W-1:0]  cnt;
  logic [BAND_W-1:0] band;
  logic              tmr_clr;
  logic              settle_end, cal_tmo, lock_tmo;

  seq_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({dll_rdy_in, cal_done_in}), .q(stat_s)
  );
  assign cal_s = stat_s[0];
  assign dll_s = stat_s[1];

  seq_band #(.RATE_W(RATE_W)) u_band (.rate(rate_q), .code(band));

  seq_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .tick(us_tick), .cnt(cnt)
  );

  assign settle_end = (st_q == ST_SETTLE) && us_tick && (cnt == SETTLE_END);
  assign cal_tmo    = (st_q == ST_CAL_W) && !cal_s && us_tick && (cnt == CAL_END);
  assign lock_tmo   = (st_q == ST_LOCK_W) && !dll_s && us_tick && (cnt == LOCK_END);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (req_valid) st_d = req_on ? ST_TXSEL : ST_PDB_LO;
      ST_TXSEL:  st_d = ST_OTEN;
      ST_OTEN:   st_d = ST_OTSEL;
      ST_OTSEL:  st_d = ST_PDB_LO;
      ST_PDB_LO: st_d = ST_DLL_LO;
      ST_DLL_LO: st_d = on_q ? ST_SETTLE : ST_IDLE;
      ST_SETTLE: if (settle_end) st_d = ST_CAL_W;
      ST_CAL_W:  if (cal_s) st_d = ST_FREQ;
                 else if (cal_tmo) st_d = ST_IDLE;
      ST_FREQ:   st_d = ST_DLL_ON;
      ST_DLL_ON: st_d = (rate_q == '0) ? ST_IDLE : ST_LOCK_W;
      ST_LOCK_W: if (dll_s || lock_tmo) st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  assign tmr_clr = (st_d != st_q);
  assign busy    = (st_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;  on_q <= 1'b0;  rate_q <= '0;
      pwr_dn_b <= 1'b0; dll_en <= 1'b0; freq_sel <= '0;
      txclk_dly_sel <= 1'b0; otap_en <= 1'b0; otap_sel <= '0;
      done <= 1'b0; err_cal <= 1'b0; err_lock <= 1'b0; warn_fast <= 1'b0;
    end else begin
      st_q <= st_d;
      unique case (st_q)
        ST_IDLE: if (req_valid) begin
          on_q      <= req_on;
          rate_q    <= rate_mhz;
          done      <= 1'b0;
          err_cal   <= 1'b0;
          err_lock  <= 1'b0;
          warn_fast <= req_on && (rate_mhz > WARN_LIM);
        end
        ST_TXSEL:  txclk_dly_sel <= 1'b1;
        ST_OTEN:   otap_en <= 1'b1;
        ST_OTSEL:  otap_sel <= TAP_CODE;
        ST_PDB_LO: pwr_dn_b <= 1'b0;
        ST_DLL_LO: begin
          dll_en <= 1'b0;
          if (!on_q) done <= 1'b1;
        end
        ST_SETTLE: if (settle_end) pwr_dn_b <= 1'b1;
        ST_CAL_W:  if (cal_tmo) err_cal <= 1'b1;
        ST_FREQ:   freq_sel <= band;
        ST_DLL_ON: begin
          dll_en <= 1'b1;
          if (rate_q == '0) done <= 1'b1;
        end
        ST_LOCK_W: begin
          if (dll_s) done <= 1'b1;
          else if (lock_tmo) err_lock <= 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/phy_pwr_seq_chk.sv
module phy_pwr_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pwr_dn_b,
  input logic       dll_en,
  input logic [2:0] freq_sel,
  input logic       txclk_dly_sel,
  input logic       otap_en,
  input logic [3:0] otap_sel,
  input logic       busy,
  input logic       done,
  input logic       err_cal,
  input logic       err_lock
);
  // R2
  pdb_then_dll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_dn_b) |=> !dll_en);

  // R4
  pdb_rise_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_dn_b) |-> (!dll_en && txclk_dly_sel && otap_en && otap_sel != 4'd0 && busy));

  // R6
  dll_after_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dll_en) |-> (pwr_dn_b && $stable(freq_sel)));

  // R5
  err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_cal || err_lock) |-> (!busy && !done && !(err_cal && err_lock)));

  // R11
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (!done && !err_cal && !err_lock));

  // R2
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind phy_pwr_seq phy_pwr_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .pwr_dn_b(pwr_dn_b), .dll_en(dll_en),
  .freq_sel(freq_sel), .txclk_dly_sel(txclk_dly_sel), .otap_en(otap_en),
  .otap_sel(otap_sel), .busy(busy), .done(done), .err_cal(err_cal),
  .err_lock(err_lock)
);

// File: tb/phy_pwr_seq_tb_top.sv
`timescale 1ns/1ps
module phy_pwr_seq_tb_top;
  localparam int SET_US = 5, CAL_US = 20, LCK_US = 40, TICK_DIV = 4;

  logic clk = 0, rst_n = 0, us_tick = 0, req_valid = 0, req_on = 0;
  logic [8:0] rate_mhz = '0;
  logic cal_done_in = 0, dll_rdy_in = 0;
  logic pwr_dn_b, dll_en, txclk_dly_sel, otap_en, busy, done, err_cal, err_lock, warn_fast;
  logic [2:0] freq_sel;
  logic [3:0] otap_sel;

  int total = 0, bad = 0, tdiv = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  phy_pwr_seq #(.RATE_W(9), .SETTLE_US(SET_US), .CAL_TMO_US(CAL_US),
                .LOCK_TMO_US(LCK_US)) dut_i (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .req_valid(req_valid),
    .req_on(req_on), .rate_mhz(rate_mhz), .cal_done_in(cal_done_in),
    .dll_rdy_in(dll_rdy_in), .pwr_dn_b(pwr_dn_b), .dll_en(dll_en),
    .freq_sel(freq_sel), .txclk_dly_sel(txclk_dly_sel), .otap_en(otap_en),
    .otap_sel(otap_sel), .busy(busy), .done(done), .err_cal(err_cal),
    .err_lock(err_lock), .warn_fast(warn_fast));

  always @(negedge clk) begin
    tdiv = (tdiv + 1) % TICK_DIV;
    us_tick <= (tdiv == 0);
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int band_of(input int r);
    int lows[5] = '{170, 140, 110, 80, 50};
    for (int i = 0; i < 5; i++)
      if (r >= lows[i] && r <= lows[i] + 30) return i;
    return 0;
  endfunction

  // behavioural reference
  int ph = 0, m_n = 0, m_rate = 0, nxt;
  bit m_on = 0, c1 = 0, c2 = 0, d1 = 0, d2 = 0, cs, ds;
  bit e_pdb = 0, e_dll = 0, e_tx = 0, e_oten = 0, e_done = 0, e_ec = 0, e_el = 0, e_warn = 0;
  int e_fs = 0, e_osel = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; m_n = 0; c1 = 0; c2 = 0; d1 = 0; d2 = 0;
      e_pdb = 0; e_dll = 0; e_tx = 0; e_oten = 0; e_done = 0; e_ec = 0;
      e_el = 0; e_warn = 0; e_fs = 0; e_osel = 0;
    end else begin
      cs = c2; ds = d2; c2 = c1; c1 = cal_done_in; d2 = d1; d1 = dll_rdy_in;
      nxt = ph;
      case (ph)
        0: if (req_valid) begin
             m_on = req_on; m_rate = rate_mhz; e_done = 0; e_ec = 0; e_el = 0;
             e_warn = req_on && (rate_mhz > 175);
             nxt = req_on ? 1 : 4;
           end
        1: begin e_tx = 1; nxt = 2; end
        2: begin e_oten = 1; nxt = 3; end
        3: begin e_osel = 2; nxt = 4; end
        4: begin e_pdb = 0; nxt = 5; end
        5: begin e_dll = 0; if (m_on) nxt = 6; else begin e_done = 1; nxt = 0; end end
        6: if (us_tick && m_n == SET_US) begin e_pdb = 1; nxt = 7; end
        7: if (cs) nxt = 8;
           else if (us_tick && m_n == CAL_US - 1) begin e_ec = 1; nxt = 0; end
        8: begin e_fs = band_of(m_rate); nxt = 9; end
        9: begin e_dll = 1; if (m_rate == 0) begin e_done = 1; nxt = 0; end else nxt = 10; end
        10: if (ds) begin e_done = 1; nxt = 0; end
            else if (us_tick && m_n == LCK_US - 1) begin e_el = 1; nxt = 0; end
        default: nxt = 0;
      endcase
      if (nxt != ph) m_n = 0; else if (us_tick) m_n++;
      ph = nxt;
    end
  end

  always @(negedge clk) if (rst_n && !finished) begin
    chk(pwr_dn_b == e_pdb, "R4 pwr_dn_b", pwr_dn_b, e_pdb);
    chk(dll_en == e_dll, "R6 dll_en", dll_en, e_dll);
    chk(freq_sel == e_fs, "R6 freq_sel", freq_sel, e_fs);
    chk(txclk_dly_sel == e_tx && otap_en == e_oten && otap_sel == e_osel,
        "R3 tx/otap", {txclk_dly_sel, otap_en, otap_sel}, {e_tx, e_oten, e_osel[3:0]});
    chk(busy == (ph != 0), "R11 busy", busy, ph != 0);
    chk(done == e_done, "R2 done", done, e_done);
    chk(err_cal == e_ec, "R5 err_cal", err_cal, e_ec);
    chk(err_lock == e_el, "R8 err_lock", err_lock, e_el);
    chk(warn_fast == e_warn, "R9 warn_fast", warn_fast, e_warn);
  end

  task automatic send(input bit on, input int r);
    @(negedge clk); req_valid = 1; req_on = on; rate_mhz = 9'(r);
    @(negedge clk); req_valid = 0;
  endtask

  task automatic run_on(input int r, input bit give_cal, input bit give_dll);
    cal_done_in = 0; dll_rdy_in = 0;
    send(1, r);
    while (pwr_dn_b) @(negedge clk);
    while (!pwr_dn_b && busy) @(negedge clk);
    repeat (3) @(negedge clk);
    cal_done_in = give_cal;
    while (busy && !dll_en) @(negedge clk);
    if (busy) begin
      repeat (2) @(negedge clk);
      if (give_dll) begin
        int k = 0;
        dll_rdy_in = 1;
        while (!done && k < 10) begin @(negedge clk); k++; end
        chk(k == 3, "R10 sync latency", k, 3);
      end
    end
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1; total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int rates[9] = '{200, 170, 169, 140, 110, 80, 50, 49, 201};
    repeat (3) @(negedge clk);
    chk({pwr_dn_b, dll_en, freq_sel, txclk_dly_sel, otap_en, otap_sel, busy, done,
         err_cal, err_lock, warn_fast} == '0, "R1 reset", busy, 0);
    rst_n = 1;
    @(negedge clk);

    // R2 power-off
    send(0, 0);
    while (busy) @(negedge clk);
    chk(done && !pwr_dn_b && !dll_en, "R2 off done", done, 1);

    // R11 ignored request during busy, then R5 calibration timeout
    cal_done_in = 0;
    send(1, 120);
    repeat (8) @(negedge clk);
    send(0, 0);
    repeat (3) @(negedge clk);
    chk(busy && !done, "R11 ignore while busy", busy, 1);
    while (busy) @(negedge clk);
    chk(err_cal && !dll_en, "R5 cal timeout", err_cal, 1);

    // R8/R9 lock timeout at high rate
    run_on(190, 1, 0);
    chk(err_lock && !err_cal, "R8 lock timeout", err_lock, 1);
    chk(warn_fast, "R9 warn set", warn_fast, 1);
    chk(freq_sel == 0, "R6 band 190", freq_sel, 0);

    // R8 normal lock
    run_on(100, 1, 1);
    chk(done && !err_lock && !warn_fast, "R8 lock done", done, 1);
    chk(freq_sel == 3, "R6 band 100", freq_sel, 3);

    // R7 zero rate
    run_on(0, 1, 1);
    chk(done && dll_en && !err_lock, "R7 zero rate done", done, 1);

    // R6 band edges
    foreach (rates[i]) begin
      run_on(rates[i], 1, 1);
      chk(int'(freq_sel) == band_of(rates[i]), "R6 band edge", freq_sel, band_of(rates[i]));
      chk(warn_fast == (rates[i] > 175), "R9 warn edge", warn_fast, rates[i] > 175);
    end

    send(0, 0);
    while (busy) @(negedge clk);
    chk(done && !pwr_dn_b, "R2 final off", done, 1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule